// File: doc/BRIEF.md
# Capability BAR Region Decoder

This block sits behind a 512 KiB memory window of a paravirtual PCI function and splits every byte access into one of six regions: the common configuration block, a one-byte interrupt status register, the device-specific configuration area, the queue notification area, the MSI-X vector table and the MSI-X pending-bit array. The four regions whose contents live elsewhere each get their own sub-port. A sub-port carries read and write strobes and an offset that is relative to the region's own base. The write byte is shared by all sub-ports.

Two regions are handled inside the block. The interrupt status byte is a local register. Interrupt sources set its bits through a status-set input. A bus read returns the byte and empties it, and a bus write clears the bits that are 1 in the written data. Writes to the notification area are turned into one-cycle doorbell pulses, one per queue. Queues are spaced four bytes apart.

Read data is registered. It appears on the cycle after the read strobe and holds until the next read. Read and write strobes are expected to be exclusive. If both are high in the same cycle, the read is served and the write is dropped.

Top module: `bar_region_router`

## Requirements
- R1: Offsets 0 to 55 select the common configuration port (cc_rd or cc_wr) with cc_off equal to the offset; no other sub-port strobe is active in that cycle.
- R2: Offsets 0x4000 to 0x4FFF select the device configuration port with dc_off equal to the offset minus 0x4000.
- R3: A read at offset 0x2000 returns the interrupt status byte and leaves the register zero when no status bit is being set in that cycle.
- R4: A write at offset 0x2000 clears exactly those status bits that are 1 in the written byte and leaves the other bits unchanged.
- R5: Offsets 0x8000 to 0x47FFF select the vector table port with vt_off equal to the offset minus 0x8000; offsets 0x48000 to 0x487FF select the pending-array port with pb_off equal to the offset minus 0x48000.
- R6: A write at offset 0x6000 + 4*i with i below NUM_Q pulses doorbell bit i for exactly one cycle, on the cycle after the write. A write in the notification area that is not a multiple of 4, or whose queue index is NUM_Q or more, pulses nothing.
- R7: Reads in the notification area return 0 and ring no doorbell.
- R8: Offsets outside every region (56 to 0x1FFF, 0x2001 to 0x3FFF, 0x5000 to 0x5FFF, 0x7000 to 0x7FFF, 0x48800 and above) read as 0, raise no sub-port strobe and change no state.
- R9: bus_rdata takes a new value on the clock edge that ends the read strobe cycle; during the strobe cycle it still shows the previous read's result, and it holds between reads.
- R10: A status bit set in the same cycle as a read or a write clear of the status register is kept and is returned by the next read.
- R11: After reset, bus_rdata, doorbell and the status register are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 19 | Byte offset within the BAR |
| bus_wdata | input | 8 | Write byte |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data |
| sub_wdata | output | 8 | Write byte shared by all sub-ports |
| cc_rd | output | 1 | Common configuration read strobe |
| cc_wr | output | 1 | Common configuration write strobe |
| cc_off | output | 6 | Common configuration offset |
| cc_rdata | input | 8 | Common configuration read data |
| dc_rd | output | 1 | Device configuration read strobe |
| dc_wr | output | 1 | Device configuration write strobe |
| dc_off | output | 12 | Device configuration offset |
| dc_rdata | input | 8 | Device configuration read data |
| vt_rd | output | 1 | Vector table read strobe |
| vt_wr | output | 1 | Vector table write strobe |
| vt_off | output | 18 | Vector table offset |
| vt_rdata | input | 8 | Vector table read data |
| pb_rd | output | 1 | Pending array read strobe |
| pb_wr | output | 1 | Pending array write strobe |
| pb_off | output | 11 | Pending array offset |
| pb_rdata | input | 8 | Pending array read data |
| isr_set | input | ISR_W | Per-bit status set requests |
| doorbell | output | NUM_Q | One-cycle per-queue notification pulses |

## Verification
A wrong region decode shows up in the same cycle: a strobe goes to the wrong sub-port, carries the wrong relative offset, or appears outside every region. A bad status register shows up on the very next read of offset 0x2000. It can return stale bits after a read, keep bits that a write should have cleared, or lose a bit set during a clear. A doorbell decoding fault is visible one cycle after the write, as a wrong, missing or spurious pulse, or as a pulse that lasts too long.

// File: rtl/bar_map_pkg.sv
package bar_map_pkg;

  localparam int unsigned DATA_W     = 8;
  localparam int unsigned BAR_SIZE   = 32'h80000;
  localparam int unsigned BAR_ADDR_W = $clog2(BAR_SIZE);

  localparam int unsigned CC_BASE = 32'h0000;
  localparam int unsigned CC_SIZE = 56;
  localparam int unsigned IS_BASE = 32'h2000;
  localparam int unsigned IS_SIZE = 1;
  localparam int unsigned DC_BASE = 32'h4000;
  localparam int unsigned DC_SIZE = 32'h1000;
  localparam int unsigned NT_BASE = 32'h6000;
  localparam int unsigned NT_SIZE = 32'h1000;
  localparam int unsigned VT_BASE = 32'h8000;
  localparam int unsigned VT_SIZE = 32'h40000;
  localparam int unsigned PB_BASE = 32'h48000;
  localparam int unsigned PB_SIZE = 32'h800;

  localparam int unsigned NOTIFY_STRIDE = 4;

  localparam int unsigned CC_OFF_W = $clog2(CC_SIZE);
  localparam int unsigned DC_OFF_W = $clog2(DC_SIZE);
  localparam int unsigned NT_OFF_W = $clog2(NT_SIZE);
  localparam int unsigned VT_OFF_W = $clog2(VT_SIZE);
  localparam int unsigned PB_OFF_W = $clog2(PB_SIZE);
  localparam int unsigned REL_W    = VT_OFF_W;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_COMMON,
    RG_STATUS,
    RG_DEVCFG,
    RG_NOTIFY,
    RG_VTAB,
    RG_PEND
  } region_e;

endpackage

// File: rtl/bar_decode.sv
module bar_decode
  import bar_map_pkg::*;
(
  input  logic [BAR_ADDR_W-1:0] addr,
  output region_e               region,
  output logic [REL_W-1:0]      rel
);

  logic [31:0] a;
  assign a = 32'(addr);

  function automatic logic in_win(input logic [31:0] x,
                                  input int unsigned base,
                                  input int unsigned size);
    return (x >= base) && (x < base + size);
  endfunction

  always_comb begin
    region = RG_NONE;
    rel    = '0;
    if (in_win(a, CC_BASE, CC_SIZE)) begin
      region = RG_COMMON;
      rel    = REL_W'(a - CC_BASE);
    end else if (in_win(a, IS_BASE, IS_SIZE)) begin
      region = RG_STATUS;
      rel    = '0;
    end else if (in_win(a, DC_BASE, DC_SIZE)) begin
      region = RG_DEVCFG;
      rel    = REL_W'(a - DC_BASE);
    end else if (in_win(a, NT_BASE, NT_SIZE)) begin
      region = RG_NOTIFY;
      rel    = REL_W'(a - NT_BASE);
    end else if (in_win(a, VT_BASE, VT_SIZE)) begin
      region = RG_VTAB;
      rel    = REL_W'(a - VT_BASE);
    end else if (in_win(a, PB_BASE, PB_SIZE)) begin
      region = RG_PEND;
      rel    = REL_W'(a - PB_BASE);
    end
  end

endmodule

// File: rtl/isr_status.sv
module isr_status #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_hit,
  input  logic         wr_hit,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] set_in,
  output logic [W-1:0] status_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
    end else if (rd_hit) begin
      status_q <= set_in;
    end else if (wr_hit) begin
      status_q <= (status_q & ~clr_mask) | set_in;
    end else begin
      status_q <= status_q | set_in;
    end
  end

endmodule

// File: rtl/notify_doorbell.sv
module notify_doorbell #(
  parameter int unsigned NUM_Q  = 4,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned STRIDE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [OFF_W-1:0] off,
  output logic [NUM_Q-1:0] ring_q
);

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    localparam logic [OFF_W-1:0] SLOT = OFF_W'(q * STRIDE);
    always_ff @(posedge clk) begin
      if (rst) ring_q[q] <= 1'b0;
      else     ring_q[q] <= wr_hit && (off == SLOT);
    end
  end

endmodule

// File: rtl/bar_region_router.sv
module bar_region_router
  import bar_map_pkg::*;
#(
  parameter int unsigned NUM_Q = 4,
  parameter int unsigned ISR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [BAR_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic                  bus_rd,
  input  logic                  bus_wr,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic [DATA_W-1:0]     sub_wdata,
  output logic                  cc_rd,
  output logic                  cc_wr,
  output logic [CC_OFF_W-1:0]   cc_off,
  input  logic [DATA_W-1:0]     cc_rdata,
  output logic                  dc_rd,
  output logic                  dc_wr,
  output logic [DC_OFF_W-1:0]   dc_off,
  input  logic [DATA_W-1:0]     dc_rdata,
  output logic                  vt_rd,
  output logic                  vt_wr,
  output logic [VT_OFF_W-1:0]   vt_off,
  input  logic [DATA_W-1:0]     vt_rdata,
  output logic                  pb_rd,
  output logic                  pb_wr,
  output logic [PB_OFF_W-1:0]   pb_off,
  input  logic [DATA_W-1:0]     pb_rdata,
  input  logic [ISR_W-1:0]      isr_set,
  output logic [NUM_Q-1:0]      doorbell
);

  region_e            region;
  logic [REL_W-1:0]   rel;
  logic               wr_en;
  logic [ISR_W-1:0]   isr_q;
  logic [DATA_W-1:0]  rdata_q;

  assign wr_en = bus_wr && !bus_rd;

  bar_decode u_dec (
    .addr   (bus_addr),
    .region (region),
    .rel    (rel)
  );

  assign sub_wdata = bus_wdata;

  assign cc_rd  = bus_rd && (region == RG_COMMON);
  assign cc_wr  = wr_en  && (region == RG_COMMON);
  assign cc_off = rel[CC_OFF_W-1:0];
  assign dc_rd  = bus_rd && (region == RG_DEVCFG);
  assign dc_wr  = wr_en  && (region == RG_DEVCFG);
  assign dc_off = rel[DC_OFF_W-1:0];
  assign vt_rd  = bus_rd && (region == RG_VTAB);
  assign vt_wr  = wr_en  && (region == RG_VTAB);
  assign vt_off = rel[VT_OFF_W-1:0];
  assign pb_rd  = bus_rd && (region == RG_PEND);
  assign pb_wr  = wr_en  && (region == RG_PEND);
  assign pb_off = rel[PB_OFF_W-1:0];

  isr_status #(.W(ISR_W)) u_isr (
    .clk      (clk),
    .rst      (rst),
    .rd_hit   (bus_rd && (region == RG_STATUS)),
    .wr_hit   (wr_en && (region == RG_STATUS)),
    .clr_mask (bus_wdata[ISR_W-1:0]),
    .set_in   (isr_set),
    .status_q (isr_q)
  );

  notify_doorbell #(
    .NUM_Q  (NUM_Q),
    .OFF_W  (NT_OFF_W),
    .STRIDE (NOTIFY_STRIDE)
  ) u_bell (
    .clk    (clk),
    .rst    (rst),
    .wr_hit (wr_en && (region == RG_NOTIFY)),
    .off    (rel[NT_OFF_W-1:0]),
    .ring_q (doorbell)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      case (region)
        RG_COMMON: rdata_q <= cc_rdata;
        RG_STATUS: rdata_q <= DATA_W'(isr_q);
        RG_DEVCFG: rdata_q <= dc_rdata;
        RG_VTAB:   rdata_q <= vt_rdata;
        RG_PEND:   rdata_q <= pb_rdata;
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/bar_region_router_chk.sv
module bar_region_router_chk
  import bar_map_pkg::*;
#(
  parameter int unsigned NUM_Q = 4,
  parameter int unsigned ISR_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic [BAR_ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic                  bus_rd,
  input logic                  bus_wr,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic [7:0]            strobes,
  input logic [ISR_W-1:0]      isr_set,
  input logic [ISR_W-1:0]      isr_q,
  input logic [NUM_Q-1:0]      doorbell
);

  logic [31:0] a;
  logic        at_isr, in_nt, hit_any;
  assign a       = 32'(bus_addr);
  assign at_isr  = (a == IS_BASE);
  assign in_nt   = (a >= NT_BASE) && (a < NT_BASE + NT_SIZE);
  assign hit_any = (a < CC_SIZE) || at_isr || in_nt
                 || ((a >= DC_BASE) && (a < DC_BASE + DC_SIZE))
                 || ((a >= VT_BASE) && (a < PB_BASE + PB_SIZE));

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes)); // R1

  AST_NO_STROBE_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    !hit_any |-> (strobes == 8'd0)); // R8

  AST_OUTSIDE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !hit_any) |=> (bus_rdata == '0)); // R8

  AST_ISR_READ_VALUE: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && at_isr) |=> (bus_rdata == DATA_W'($past(isr_q)))); // R3

  AST_ISR_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && at_isr && isr_set == '0) |=> (isr_q == '0)); // R3

  AST_ISR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && at_isr && isr_set == '0)
      |=> (isr_q == ($past(isr_q) & ~$past(bus_wdata[ISR_W-1:0])))); // R4

  AST_SET_KEPT: assert property (@(posedge clk) disable iff (rst)
    (isr_set != '0) |=> ((isr_q & $past(isr_set)) == $past(isr_set))); // R10

  AST_BELL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(doorbell)); // R6

  AST_BELL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (doorbell != '0) |-> $past(bus_wr && !bus_rd && in_nt)); // R6

  AST_NT_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && in_nt) |=> (bus_rdata == '0)); // R7

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (bus_rdata == '0 && doorbell == '0 && isr_q == '0)); // R11

endmodule

bind bar_region_router bar_region_router_chk #(
  .NUM_Q (NUM_Q),
  .ISR_W (ISR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_rdata (bus_rdata),
  .strobes   ({cc_rd, cc_wr, dc_rd, dc_wr, vt_rd, vt_wr, pb_rd, pb_wr}),
  .isr_set   (isr_set),
  .isr_q     (isr_q),
  .doorbell  (doorbell)
);

// File: tb/test_bar_region_router.sv
module test_bar_region_router;

  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [18:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_rdata, sub_wdata;
  logic        cc_rd, cc_wr, dc_rd, dc_wr, vt_rd, vt_wr, pb_rd, pb_wr;
  logic [5:0]  cc_off;
  logic [11:0] dc_off;
  logic [17:0] vt_off;
  logic [10:0] pb_off;
  logic [7:0]  cc_rdata, dc_rdata, vt_rdata, pb_rdata;
  logic [7:0]  isr_set = '0;
  logic [NQ-1:0] doorbell;

  int checks = 0;
  int errors = 0;
  byte unsigned last_rd = 8'h00;
  byte unsigned exp_q[$];
  string        tag_q[$];
  logic         rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cc_rdata = {2'b01, cc_off};
  assign dc_rdata = dc_off[7:0] ^ 8'h5A;
  assign vt_rdata = vt_off[7:0] ^ 8'hC3;
  assign pb_rdata = pb_off[7:0] ^ 8'h3C;

  bar_region_router #(.NUM_Q(NQ), .ISR_W(8)) i_bar_region_router (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .sub_wdata(sub_wdata),
    .cc_rd(cc_rd), .cc_wr(cc_wr), .cc_off(cc_off), .cc_rdata(cc_rdata),
    .dc_rd(dc_rd), .dc_wr(dc_wr), .dc_off(dc_off), .dc_rdata(dc_rdata),
    .vt_rd(vt_rd), .vt_wr(vt_wr), .vt_off(vt_off), .vt_rdata(vt_rdata),
    .pb_rd(pb_rd), .pb_wr(pb_wr), .pb_off(pb_off), .pb_rdata(pb_rdata),
    .isr_set(isr_set), .doorbell(doorbell)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the expected read value in the cycle after the strobe.
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected read result", bus_rdata, 0);
      end else begin
        automatic byte unsigned e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(bus_rdata == e, t, "read data", bus_rdata, e);
      end
    end
  end

  // port: 0 none, 1 common, 2 devcfg, 3 vtab, 4 pend
  task automatic access(input bit is_rd, input int addr, input byte unsigned wd,
                        input int port, input int off, input byte unsigned exp,
                        input string req);
    int got, n, goff;
    bit dir_ok;
    @(negedge clk);
    bus_addr  = 19'(addr);
    bus_wdata = wd;
    bus_rd    = is_rd;
    bus_wr    = !is_rd;
    if (is_rd) begin
      exp_q.push_back(exp);
      tag_q.push_back(req);
    end
    #1;
    n = int'(cc_rd) + int'(cc_wr) + int'(dc_rd) + int'(dc_wr)
      + int'(vt_rd) + int'(vt_wr) + int'(pb_rd) + int'(pb_wr);
    got = 0; goff = 0; dir_ok = 1'b1;
    if (cc_rd || cc_wr) begin got = 1; goff = int'(cc_off); dir_ok = (cc_rd == is_rd); end
    if (dc_rd || dc_wr) begin got = 2; goff = int'(dc_off); dir_ok = (dc_rd == is_rd); end
    if (vt_rd || vt_wr) begin got = 3; goff = int'(vt_off); dir_ok = (vt_rd == is_rd); end
    if (pb_rd || pb_wr) begin got = 4; goff = int'(pb_off); dir_ok = (pb_rd == is_rd); end
    check(n <= 1 && got == port && dir_ok, req, "selected port", got, port);
    if (port != 0) check(goff == off, req, "relative offset", goff, off);
    if (!is_rd && port != 0) check(sub_wdata == wd, req, "write byte", sub_wdata, wd);
    if (is_rd) begin
      check(bus_rdata == last_rd, "R9", "data before edge", bus_rdata, last_rd);
      last_rd = exp;
    end
    @(negedge clk);
    bus_rd = 1'b0;
    bus_wr = 1'b0;
  endtask

  task automatic pulse_set(input byte unsigned v);
    @(negedge clk);
    isr_set = v;
    @(negedge clk);
    isr_set = '0;
  endtask

  task automatic bell(input int addr, input int exp, input string req);
    access(1'b0, addr, 8'hAA, 0, 0, 0, req);
    #1;
    check(doorbell == NQ'(exp), req, "doorbell pulse", doorbell, exp);
    @(negedge clk); #1;
    check(doorbell == '0, req, "doorbell width", doorbell, 0);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    check(1'b0, "R11", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(bus_rdata == 8'h00, "R11", "rdata in reset", bus_rdata, 0);
    check(doorbell == '0, "R11", "doorbell in reset", doorbell, 0);
    @(negedge clk);
    rst = 1'b0;
    access(1'b1, 32'h2000, 0, 0, 0, 8'h00, "R11");           // status empty after reset

    // common config (R1)
    access(1'b1, 0,  0, 1, 0,  8'h40, "R1");
    access(1'b1, 55, 0, 1, 55, 8'h77, "R1");
    access(1'b0, 20, 8'h33, 1, 20, 0, "R1");
    // outside regions (R8)
    access(1'b1, 56,       0, 0, 0, 8'h00, "R8");
    access(1'b0, 56, 8'h11, 0, 0, 0, "R8");
    access(1'b1, 32'h5000, 0, 0, 0, 8'h00, "R8");
    access(1'b1, 32'h48800, 0, 0, 0, 8'h00, "R8");
    access(1'b1, 32'h7FFFF, 0, 0, 0, 8'h00, "R8");
    // device config (R2)
    access(1'b1, 32'h4000, 0, 2, 0,     8'h5A, "R2");
    access(1'b1, 32'h4FFF, 0, 2, 'hFFF, 8'hA5, "R2");
    access(1'b0, 32'h4010, 8'h99, 2, 'h10, 0, "R2");
    // vector table and pending array (R5)
    access(1'b1, 32'h8000,  0, 3, 0,       8'hC3, "R5");
    access(1'b1, 32'h47FFF, 0, 3, 'h3FFFF, 8'h3C, "R5");
    access(1'b0, 32'h8123,  8'h5C, 3, 'h123, 0, "R5");
    access(1'b1, 32'h48000, 0, 4, 0,     8'h3C, "R5");
    access(1'b1, 32'h487FF, 0, 4, 'h7FF, 8'hC3, "R5");
    // doorbells (R6, R7)
    bell(32'h6000, 1, "R6");
    bell(32'h600C, 8, "R6");
    bell(32'h6004, 2, "R6");
    bell(32'h6002, 0, "R6");
    bell(32'h6010, 0, "R6");
    access(1'b1, 32'h6004, 0, 0, 0, 8'h00, "R7");
    #1;
    check(doorbell == '0, "R7", "no bell on read", doorbell, 0);
    // status register (R3, R4, R10, R8)
    pulse_set(8'h05);
    access(1'b1, 32'h2000, 0, 0, 0, 8'h05, "R3");
    access(1'b1, 32'h2000, 0, 0, 0, 8'h00, "R3");
    pulse_set(8'h0F);
    access(1'b0, 32'h2000, 8'h03, 0, 0, 0, "R4");
    access(1'b1, 32'h2000, 0, 0, 0, 8'h0C, "R4");
    pulse_set(8'h02);
    @(negedge clk);
    bus_addr = 19'h2000; bus_rd = 1'b1; isr_set = 8'h01;
    exp_q.push_back(8'h02); tag_q.push_back("R10"); last_rd = 8'h02;
    @(negedge clk);
    bus_rd = 1'b0; isr_set = '0;
    access(1'b1, 32'h2000, 0, 0, 0, 8'h01, "R10");
    pulse_set(8'h30);
    @(negedge clk);
    bus_addr = 19'h2000; bus_wdata = 8'hFF; bus_wr = 1'b1; isr_set = 8'h40;
    @(negedge clk);
    bus_wr = 1'b0; isr_set = '0;
    access(1'b1, 32'h2000, 0, 0, 0, 8'h40, "R10");
    pulse_set(8'h80);
    access(1'b0, 32'h2001, 8'hFF, 0, 0, 0, "R8");
    access(1'b1, 32'h2000, 0, 0, 0, 8'h80, "R8");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9", "reads left unanswered", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule